// File: doc/BRIEF.md
# SCR-Driven 90 kHz Timebase Updater

This block keeps the 33-bit system time counter that a stream decoder uses for audio/video synchronization. The counter advances by one on every pulse of a 90 kHz tick. Stream clock reference (SCR) values taken from the incoming stream may overwrite the counter. A control byte decides which SCRs are allowed to do so. The first SCR after reset, or after a play-mode change, always loads the counter. After that, either every later SCR is refused (one-shot mode), or an SCR is accepted only once a minimum number of ticks has passed since the last accepted load.

The same control byte carries two enables, one for audio and one for video. They decide whether presentation time stamp (PTS) strobes reach the audio decoder and the video decoder. The control byte is written through a simple write strobe and takes effect on the cycle after the write.

Top module: `scr_timebase`

## Requirements
- R1: After reset the counter reads 0 and the control byte is 0x78. In that state bit 5 = 1 and bit 4 = 1, so both PTS paths are enabled. Bit 2 = 0, so interval mode is selected, and bits 1:0 = 00 select the longest interval. The next SCR is treated as a first SCR.
- R2: On a cycle with `tick` high and no accepted SCR, the counter increments by one. It wraps from 2^33-1 to 0.
- R3: The first SCR after reset or after a play-mode change is always accepted. `stc` equals `scr_val` on the cycle after the strobe, and a tick in the same cycle is overridden by the load.
- R4: With bit 2 clear, a later SCR is accepted only if at least N ticks have been counted since the last accepted load. N is 8·B, 4·B, 2·B or 1·B for bits 1:0 = 00, 01, 10 or 11 respectively, where B is `BASE_TICKS` (8100 gives 720/360/180/90 ms). An earlier SCR leaves the counter untouched.
- R5: With bit 2 set, every SCR after the first one following a play-mode change is ignored, whatever bits 1:0 hold.
- R6: A `mode_chg` pulse re-arms first-SCR acceptance and restarts the interval count. An SCR strobed in the same cycle as the pulse is accepted.
- R7: `a_pts_out` equals `a_pts_in` when control bit 5 is 1 and is 0 otherwise. It is combinational, with no added delay.
- R8: `v_pts_out` equals `v_pts_in` when control bit 4 is 1 and is 0 otherwise. It is combinational, with no added delay.
- R9: A control write with `ctrl_we` high governs acceptance and gating from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_we | input | 1 | Control byte write strobe |
| ctrl_wdata | input | 8 | Control byte value |
| tick | input | 1 | 90 kHz tick pulse, one cycle wide |
| scr_vld | input | 1 | SCR present strobe |
| scr_val | input | 33 | SCR value |
| mode_chg | input | 1 | Play-mode change pulse |
| a_pts_in | input | 1 | Audio PTS strobe from demultiplexer |
| v_pts_in | input | 1 | Video PTS strobe from demultiplexer |
| stc | output | 33 | System time counter |
| a_pts_out | output | 1 | Gated audio PTS strobe |
| v_pts_out | output | 1 | Gated video PTS strobe |

## Verification
The hardest case to reach is the exact interval boundary. An SCR must arrive on the very cycle the tick count since the last load reaches N, and one cycle earlier it must be refused. The bench reaches this point for each of the four interval codes by shrinking `BASE_TICKS`. After a first load, it strobes an SCR on every cycle while ticking on every cycle, so that both the last refused SCR and the first accepted SCR occur. A behavioural reference model, compared on every clock, judges each of these SCRs.

// File: rtl/scr_timebase.sv
module scr_timebase #(
  parameter int STC_W      = 33,
  parameter int BASE_TICKS = 8100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_we,
  input  logic [7:0]       ctrl_wdata,
  input  logic             tick,
  input  logic             scr_vld,
  input  logic [STC_W-1:0] scr_val,
  input  logic             mode_chg,
  input  logic             a_pts_in,
  input  logic             v_pts_in,
  output logic [STC_W-1:0] stc,
  output logic             a_pts_out,
  output logic             v_pts_out
);

  localparam int MAXT = 8 * BASE_TICKS;
  localparam int TW   = $clog2(MAXT + 1);
  localparam logic [7:0] CTRL_RST = 8'h78;

  logic [7:0]       ctrl_q;
  logic             armed_q;
  logic [TW-1:0]    tmr_q;
  logic [TW-1:0]    limit;
  logic             one_shot, elapsed, take;

  assign one_shot = ctrl_q[2];

  always_comb begin
    case (ctrl_q[1:0])
      2'b00:   limit = TW'(8 * BASE_TICKS);
      2'b01:   limit = TW'(4 * BASE_TICKS);
      2'b10:   limit = TW'(2 * BASE_TICKS);
      default: limit = TW'(BASE_TICKS);
    endcase
  end

  assign elapsed = (tmr_q >= limit);
  assign take    = scr_vld && (armed_q || mode_chg || (!one_shot && elapsed));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
    end else if (ctrl_we) begin
      ctrl_q <= ctrl_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b1;
      tmr_q   <= '0;
    end else if (take) begin
      armed_q <= 1'b0;
      tmr_q   <= '0;
    end else if (mode_chg) begin
      armed_q <= 1'b1;
      tmr_q   <= '0;
    end else if (tick && tmr_q != TW'(MAXT)) begin
      tmr_q   <= tmr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    stc <= '0;
    else if (take) stc <= scr_val;
    else if (tick) stc <= stc + 1'b1;
  end

  assign a_pts_out = a_pts_in & ctrl_q[5];
  assign v_pts_out = v_pts_in & ctrl_q[4];

  a_r2_tick_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !scr_vld) |=> stc == $past(stc) + 1'b1);

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !scr_vld) |=> $stable(stc));

  a_r6_same_cycle_load: assert property (@(posedge clk) disable iff (!rst_n)
    (scr_vld && mode_chg) |=> stc == $past(scr_val));

  a_r5_one_shot_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (scr_vld && !mode_chg && one_shot && !armed_q && !tick) |=> $stable(stc));

  a_r4_timer_bound: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_q <= TW'(MAXT));

  a_r7_audio_gate: assert property (@(posedge clk) disable iff (!rst_n)
    a_pts_out |-> (a_pts_in && ctrl_q[5]));

  a_r8_video_gate: assert property (@(posedge clk) disable iff (!rst_n)
    v_pts_out |-> (v_pts_in && ctrl_q[4]));

endmodule

// File: tb/scr_timebase_tb.sv
`timescale 1ns/1ps
module scr_timebase_tb_top;
  localparam int BASE = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        ctrl_we = 0;
  logic [7:0]  ctrl_wdata = 0;
  logic        tick = 0, scr_vld = 0, mode_chg = 0, a_pts_in = 0, v_pts_in = 0;
  logic [32:0] scr_val = 0;
  logic [32:0] stc;
  logic        a_pts_out, v_pts_out;

  int nrun = 0, nfail = 0;
  bit done = 0;
  string cur_req = "R1";

  logic [32:0] m_stc;
  logic [7:0]  m_ctrl;
  bit          m_armed;
  int          m_ticks;

  always #2.5 clk = ~clk;

  scr_timebase #(.STC_W(33), .BASE_TICKS(BASE)) dut_i (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .tick(tick), .scr_vld(scr_vld), .scr_val(scr_val), .mode_chg(mode_chg),
    .a_pts_in(a_pts_in), .v_pts_in(v_pts_in),
    .stc(stc), .a_pts_out(a_pts_out), .v_pts_out(v_pts_out));

  always @(posedge clk) begin
    if (!rst_n) begin
      m_stc = 0; m_ctrl = 8'h78; m_armed = 1; m_ticks = 0;
    end else begin
      int lim;
      bit ok;
      lim = BASE * (8 >> m_ctrl[1:0]);
      ok  = scr_vld && (m_armed || mode_chg || (!m_ctrl[2] && m_ticks >= lim));
      if (ok) begin
        m_stc = scr_val; m_armed = 0; m_ticks = 0;
      end else begin
        if (tick) m_stc = m_stc + 33'd1;
        if (mode_chg) begin m_armed = 1; m_ticks = 0; end
        else if (tick) m_ticks++;
      end
      if (ctrl_we) m_ctrl = ctrl_wdata;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      nrun++;
      if (stc !== m_stc) begin
        nfail++;
        $display("FAIL %s stc actual=%h expected=%h", cur_req, stc, m_stc);
      end
      nrun++;
      if (a_pts_out !== (a_pts_in & m_ctrl[5]) || v_pts_out !== (v_pts_in & m_ctrl[4])) begin
        nfail++;
        $display("FAIL %s pts actual=%b%b expected=%b%b", cur_req, a_pts_out, v_pts_out,
                 a_pts_in & m_ctrl[5], v_pts_in & m_ctrl[4]);
      end
    end
  end

  task automatic cyc(input bit tk, input bit sv, input logic [32:0] val, input bit mc);
    tick = tk; scr_vld = sv; scr_val = val; mode_chg = mc;
    ctrl_we = 0; a_pts_in = $urandom % 2; v_pts_in = $urandom % 2;
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [7:0] v);
    tick = 0; scr_vld = 0; mode_chg = 0; ctrl_we = 1; ctrl_wdata = v;
    @(posedge clk); #1;
    ctrl_we = 0;
  endtask

  function automatic logic [32:0] rnd33();
    return {1'($urandom), 32'($urandom)};
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    cur_req = "R1";
    nrun++;
    if (stc !== 33'd0) begin nfail++; $display("FAIL R1 reset stc actual=%h expected=0", stc); end
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0);

    cur_req = "R2";
    for (int i = 0; i < 20; i++) cyc(1, 0, 0, 0);

    cur_req = "R3";
    cyc(1, 1, 33'h1_FFFF_FFFD, 0);
    cur_req = "R2";
    for (int i = 0; i < 6; i++) cyc(1, 0, 0, 0);
    nrun++;
    if (stc !== 33'd3) begin nfail++; $display("FAIL R2 wrap stc actual=%h expected=3", stc); end

    cur_req = "R4";
    for (int s = 0; s < 4; s++) begin
      wr(8'h78 | 8'(s));
      cyc(0, 1, rnd33(), 1);
      for (int i = 0; i < BASE * (8 >> s) + 4; i++) cyc(1, 1, rnd33(), 0);
      for (int i = 0; i < 30; i++) cyc(i % 3 == 0, i % 2 == 0, rnd33(), 0);
    end

    cur_req = "R5";
    for (int s = 0; s < 4; s++) begin
      wr(8'h7C | 8'(s));
      cyc(1, 0, 0, 1);
      cyc(0, 1, rnd33(), 0);
      for (int i = 0; i < 3 * BASE * 8; i++) cyc(1, i % 5 == 0, rnd33(), 0);
    end

    cur_req = "R6";
    wr(8'h7B);
    cyc(1, 1, rnd33(), 1);
    cyc(1, 1, rnd33(), 0);
    cyc(1, 0, 0, 1);
    for (int i = 0; i < 5; i++) cyc(1, 0, 0, 0);
    cyc(1, 1, rnd33(), 0);
    cyc(1, 1, rnd33(), 1);

    cur_req = "R7";
    wr(8'h58);
    for (int i = 0; i < 20; i++) cyc(1, 0, 0, 0);
    cur_req = "R8";
    wr(8'h68);
    for (int i = 0; i < 20; i++) cyc(1, 0, 0, 0);
    wr(8'h48);
    for (int i = 0; i < 10; i++) cyc(1, 0, 0, 0);

    cur_req = "R9";
    for (int i = 0; i < 3000; i++) begin
      if ($urandom % 40 == 0) wr(8'($urandom));
      else cyc($urandom % 2, $urandom % 8 == 0, rnd33(), $urandom % 60 == 0);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nrun, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      nrun++; nfail++;
      $display("FAIL %s watchdog expired", cur_req);
      $display("  [TB] %0d tests run, %0d failed", nrun, nfail);
      $finish;
    end
  end
endmodule